// File: doc/BRIEF.md
# Receive Frame Error Classifier

This block watches the beat stream of a receive MAC client path and builds one error vector per received Ethernet frame. During the frame it keeps two sticky flags: whether a non-terminate control character has been seen, and whether an error character has been seen. On the end-of-packet beat it combines these flags with the upstream CRC verdict, a truncation flag, the total frame length, the length/type field and the received payload length.

It then applies fixed masking rules between the error classes. A malformed frame hides the size error. A size error or a malformed frame hides the payload-length error. Frames of eight bytes or fewer are dropped without any report.

The result is registered once. It appears one clock after the end-of-packet beat as a single-cycle report strobe with a 6-bit vector. The block does not compute the CRC and does not decode PCS characters; both arrive as flags.

Top module: `rxerr_classify`

## Requirements
- R1: For a valid end-of-packet beat whose `frame_len_i` exceeds 8, `rep_valid_o` is high in exactly the next cycle and low in every other cycle. Beats without end-of-packet never raise it.
- R2: A frame whose `frame_len_i` is 8 or less produces no report: `rep_valid_o` stays low and `rep_err_o` stays zero.
- R3: Bit 0 of `rep_err_o` (malformed) is set when any valid beat of the frame has `ctrl_i` high with `ctrl_term_i` low. A control character flagged as a terminate does not set it.
- R4: Bit 1 (CRC class) is set when any of these holds: `crc_bad_i` on the end beat, `trunc_i` on the end beat, `errchar_i` on any valid beat of the frame, the frame is malformed, or `frame_len_i` is below 64.
- R5: Bit 2 (size) is set when `frame_len_i` is below 64 or above `MAX_LEN` (default 1518), except that it is clear when bit 0 is set.
- R6: Bit 4 (payload length) is set when `len_type_i` is at most 1500 and `payload_len_i` is below `len_type_i`. It is clear when the frame is undersized, oversized or malformed.
- R7: When `len_type_i` is above 1500, the value is an EtherType and bit 4 stays clear.
- R8: Bits 3 and 5 of `rep_err_o` are always zero, and the whole vector is zero in every cycle where `rep_valid_o` is low.
- R9: The sticky flags restart at each start-of-packet beat, so a previous frame's malformed or error-character state does not carry over. Beats with `beat_valid_i` low are ignored.
- R10: During and straight after reset, `rep_valid_o` is 0 and `rep_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid_i | input | 1 | Beat qualifier |
| sop_i | input | 1 | First beat of frame |
| eop_i | input | 1 | Last beat of frame |
| ctrl_i | input | 1 | A control character appears in this beat |
| ctrl_term_i | input | 1 | That control character is a terminate |
| errchar_i | input | 1 | An error character appears in this beat |
| crc_bad_i | input | 1 | Upstream CRC check failed (end beat) |
| trunc_i | input | 1 | Frame was cut short (end beat) |
| frame_len_i | input | LEN_W | Total frame byte count (end beat) |
| len_type_i | input | 16 | Length/type field (end beat) |
| payload_len_i | input | LEN_W | Received payload byte count (end beat) |
| rep_valid_o | output | 1 | Report strobe, one cycle after end beat |
| rep_err_o | output | 6 | Error vector |

## Verification
A corrupted sticky flag would show up at the ports on the next report as a bit 0 or bit 1 error on a clean frame. It would also show up as a missing bit on a frame that needs one. The bench covers this by sending a bad frame followed directly by a clean one. A wrong output register or strobe path would show up one cycle after the end beat, either as a missed strobe, a strobe after a runt, or a strobe lingering into the next cycle. Masking faults would show up on the same report as an extra or missing bit 2 or bit 4. The bench drives the boundary lengths 8/9, 63/64 and 1518/1519, and length fields of 1500 and 1501, to expose them.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    localparam int ERR_W   = 6;
    localparam int B_MAL   = 0;
    localparam int B_CRC   = 1;
    localparam int B_SIZE  = 2;
    localparam int B_PLEN  = 4;

    // flags accumulated over the beats of one frame
    typedef struct packed {
        logic mal;
        logic errc;
    } sticky_t;

    // registered report
    typedef struct packed {
        logic             vld;
        logic [ERR_W-1:0] err;
    } rep_t;

endpackage

// File: rtl/rxerr_track.sv
module rxerr_track
    import rxerr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    beat_valid_i,
    input  logic    sop_i,
    input  logic    ctrl_i,
    input  logic    ctrl_term_i,
    input  logic    errchar_i,
    output sticky_t now_o
);

    sticky_t state_d, state_q;
    sticky_t base;
    sticky_t beat;

    always_comb begin
        base      = sop_i ? sticky_t'('0) : state_q;
        beat.mal  = ctrl_i & ~ctrl_term_i;
        beat.errc = errchar_i;
        if (beat_valid_i) begin
            now_o   = base | beat;
            state_d = base | beat;
        end else begin
            now_o   = state_q;
            state_d = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/rxerr_size.sv
module rxerr_size #(
    parameter int LEN_W         = 14,
    parameter int MIN_LEN       = 64,
    parameter int MAX_LEN       = 1518,
    parameter int RUNT_LEN      = 8,
    parameter int LEN_FIELD_MAX = 1500
) (
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic [15:0]      len_type_i,
    input  logic [LEN_W-1:0] payload_len_i,
    output logic             runt_o,
    output logic             under_o,
    output logic             over_o,
    output logic             plen_short_o
);

    localparam int CW = (LEN_W > 16) ? LEN_W : 16;

    logic [CW-1:0] lt_x;
    logic [CW-1:0] pl_x;
    logic          is_length;

    always_comb begin
        lt_x         = CW'(len_type_i);
        pl_x         = CW'(payload_len_i);
        runt_o       = frame_len_i <= LEN_W'(RUNT_LEN);
        under_o      = frame_len_i <  LEN_W'(MIN_LEN);
        over_o       = frame_len_i >  LEN_W'(MAX_LEN);
        is_length    = lt_x <= CW'(LEN_FIELD_MAX);
        plen_short_o = is_length && (pl_x < lt_x);
    end

endmodule

// File: rtl/rxerr_classify.sv
module rxerr_classify
    import rxerr_pkg::*;
#(
    parameter int LEN_W         = 14,
    parameter int MIN_LEN       = 64,
    parameter int MAX_LEN       = 1518,
    parameter int RUNT_LEN      = 8,
    parameter int LEN_FIELD_MAX = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid_i,
    input  logic             sop_i,
    input  logic             eop_i,
    input  logic             ctrl_i,
    input  logic             ctrl_term_i,
    input  logic             errchar_i,
    input  logic             crc_bad_i,
    input  logic             trunc_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic [15:0]      len_type_i,
    input  logic [LEN_W-1:0] payload_len_i,
    output logic             rep_valid_o,
    output logic [5:0]       rep_err_o
);

    sticky_t flags;
    logic    runt, under, over, plen_short;
    logic    size_bad;
    rep_t    rep_d, rep_q;

    rxerr_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid_i (beat_valid_i),
        .sop_i        (sop_i),
        .ctrl_i       (ctrl_i),
        .ctrl_term_i  (ctrl_term_i),
        .errchar_i    (errchar_i),
        .now_o        (flags)
    );

    rxerr_size #(
        .LEN_W         (LEN_W),
        .MIN_LEN       (MIN_LEN),
        .MAX_LEN       (MAX_LEN),
        .RUNT_LEN      (RUNT_LEN),
        .LEN_FIELD_MAX (LEN_FIELD_MAX)
    ) u_size (
        .frame_len_i   (frame_len_i),
        .len_type_i    (len_type_i),
        .payload_len_i (payload_len_i),
        .runt_o        (runt),
        .under_o       (under),
        .over_o        (over),
        .plen_short_o  (plen_short)
    );

    always_comb begin
        size_bad = under | over;
        rep_d    = '0;
        if (beat_valid_i && eop_i && !runt) begin
            rep_d.vld         = 1'b1;
            rep_d.err[B_MAL]  = flags.mal;
            rep_d.err[B_CRC]  = crc_bad_i | trunc_i | flags.errc | flags.mal | under;
            rep_d.err[B_SIZE] = size_bad & ~flags.mal;
            rep_d.err[B_PLEN] = plen_short & ~size_bad & ~flags.mal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign rep_valid_o = rep_q.vld;
    assign rep_err_o   = rep_q.err;

endmodule

// File: rtl/rxerr_classify_chk.sv
module rxerr_classify_chk #(
    parameter int LEN_W    = 14,
    parameter int RUNT_LEN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beat_valid_i,
    input logic             eop_i,
    input logic [LEN_W-1:0] frame_len_i,
    input logic             rep_valid_o,
    input logic [5:0]       rep_err_o
);

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rep_valid_o == $past(beat_valid_i && eop_i && (frame_len_i > LEN_W'(RUNT_LEN)))));

    // R2
    runt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_i && eop_i && (frame_len_i <= LEN_W'(RUNT_LEN))) |=> !rep_valid_o);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_err_o[3] == 1'b0) && (rep_err_o[5] == 1'b0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_valid_o |-> (rep_err_o == 6'd0));

    // R4
    mal_implies_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_err_o[0] |-> rep_err_o[1]);

    // R5
    mal_hides_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_err_o[0] |-> !rep_err_o[2]);

    // R6
    masks_plen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_err_o[0] || rep_err_o[2]) |-> !rep_err_o[4]);

endmodule

bind rxerr_classify rxerr_classify_chk #(
    .LEN_W    (LEN_W),
    .RUNT_LEN (RUNT_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_valid_i (beat_valid_i),
    .eop_i        (eop_i),
    .frame_len_i  (frame_len_i),
    .rep_valid_o  (rep_valid_o),
    .rep_err_o    (rep_err_o)
);

// File: tb/test_rxerr_classify.sv
`timescale 1ns/1ps
module test_rxerr_classify;

    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             beat_valid_i = 1'b0;
    logic             sop_i = 1'b0;
    logic             eop_i = 1'b0;
    logic             ctrl_i = 1'b0;
    logic             ctrl_term_i = 1'b0;
    logic             errchar_i = 1'b0;
    logic             crc_bad_i = 1'b0;
    logic             trunc_i = 1'b0;
    logic [LEN_W-1:0] frame_len_i = '0;
    logic [15:0]      len_type_i = '0;
    logic [LEN_W-1:0] payload_len_i = '0;
    logic             rep_valid_o;
    logic [5:0]       rep_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    rxerr_classify i_rxerr_classify (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // expected vector from the requirements alone
    function automatic int model(bit mal, bit errc, bit crc, bit trn, int flen, int lt, int pl);
        bit und, ovr, sz;
        int e;
        und = flen < 64;
        ovr = flen > 1518;
        sz  = und || ovr;
        e = 0;
        if (mal) e |= 1;
        if (crc || trn || errc || mal || und) e |= 2;
        if (sz && !mal) e |= 4;
        if (lt <= 1500 && pl < lt && !sz && !mal) e |= 16;
        return e;
    endfunction

    task automatic idle();
        beat_valid_i = 0; sop_i = 0; eop_i = 0; ctrl_i = 0; ctrl_term_i = 0;
        errchar_i = 0; crc_bad_i = 0; trunc_i = 0;
    endtask

    // nb beats; mal_at / errc_at / gap_at give beat indices (-1 = none)
    task automatic run_frame(string req, int nb, int mal_at, int errc_at, bit crc, bit trn,
                             int flen, int lt, int pl, int gap_at);
        bit mid_bad = 0;
        int exp;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (i > 0 && rep_valid_o) mid_bad = 1;
            if (i == gap_at) begin
                idle();
                ctrl_i = 1; errchar_i = 1;
                @(negedge clk);
                if (rep_valid_o) mid_bad = 1;
            end
            beat_valid_i  = 1;
            sop_i         = (i == 0);
            eop_i         = (i == nb - 1);
            ctrl_i        = (i == mal_at) || (i == nb - 1);
            ctrl_term_i   = (i == nb - 1) && (i != mal_at);
            errchar_i     = (i == errc_at);
            crc_bad_i     = (i == nb - 1) && crc;
            trunc_i       = (i == nb - 1) && trn;
            frame_len_i   = LEN_W'(flen);
            len_type_i    = 16'(lt);
            payload_len_i = LEN_W'(pl);
        end
        @(negedge clk);
        idle();
        chk({req, " no strobe mid-frame (R1)"}, int'(mid_bad), 0);
        exp = model(mal_at >= 0, errc_at >= 0, crc, trn, flen, lt, pl);
        if (flen > 8) begin
            chk({req, " strobe (R1)"}, int'(rep_valid_o), 1);
            chk({req, " vector"}, int'(rep_err_o), exp);
        end else begin
            chk({req, " runt strobe (R2)"}, int'(rep_valid_o), 0);
            chk({req, " runt vector (R2)"}, int'(rep_err_o), 0);
        end
        @(negedge clk);
        chk({req, " strobe one cycle (R1)"}, int'(rep_valid_o), 0);
        chk({req, " idle vector zero (R8)"}, int'(rep_err_o), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 valid in reset", int'(rep_valid_o), 0);
        chk("R10 err in reset", int'(rep_err_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 valid after reset", int'(rep_valid_o), 0);
    endtask

    task automatic t_clean();
        run_frame("R1 clean 64", 1, -1, -1, 0, 0, 64, 46, 46, -1);
        run_frame("R3 clean 1518 terminate", 4, -1, -1, 0, 0, 1518, 16'h0800, 1500, -1);
    endtask

    task automatic t_crc_class();
        run_frame("R4 crc bad", 2, -1, -1, 1, 0, 100, 16'h0800, 86, -1);
        run_frame("R4 error char", 3, -1, 1, 0, 0, 200, 16'h0800, 186, -1);
        run_frame("R4 truncated", 2, -1, -1, 0, 1, 90, 16'h0800, 76, -1);
    endtask

    task automatic t_malformed();
        run_frame("R3 malformed mid", 3, 1, -1, 0, 0, 70, 16'h0800, 56, -1);
        run_frame("R3 malformed end beat", 2, 1, -1, 0, 0, 300, 16'h0800, 286, -1);
        run_frame("R5 malformed undersize", 1, 0, -1, 0, 0, 40, 16'h0800, 26, -1);
        run_frame("R6 malformed short payload", 2, 0, -1, 0, 0, 200, 100, 50, -1);
    endtask

    task automatic t_size();
        run_frame("R5 undersize 40", 1, -1, -1, 0, 0, 40, 16'h0800, 26, -1);
        run_frame("R5 edge 63", 1, -1, -1, 0, 0, 63, 16'h0800, 49, -1);
        run_frame("R5 edge 64", 1, -1, -1, 0, 0, 64, 16'h0800, 50, -1);
        run_frame("R5 oversize 1519", 3, -1, -1, 0, 0, 1519, 16'h0800, 1505, -1);
        run_frame("R2 runt 8", 1, -1, -1, 1, 0, 8, 16'h0800, 0, -1);
        run_frame("R2 edge 9", 1, -1, -1, 0, 0, 9, 16'h0800, 0, -1);
    endtask

    task automatic t_payload();
        run_frame("R6 short payload", 2, -1, -1, 0, 0, 200, 100, 99, -1);
        run_frame("R6 exact payload", 2, -1, -1, 0, 0, 200, 100, 100, -1);
        run_frame("R6 field 1500", 3, -1, -1, 0, 0, 1518, 1500, 1499, -1);
        run_frame("R6 oversize hides", 3, -1, -1, 0, 0, 1600, 1500, 10, -1);
        run_frame("R6 undersize hides", 1, -1, -1, 0, 0, 50, 100, 36, -1);
        run_frame("R7 field 1501", 2, -1, -1, 0, 0, 200, 1501, 10, -1);
        run_frame("R7 ethertype", 2, -1, -1, 0, 0, 200, 16'h86DD, 10, -1);
    endtask

    task automatic t_restart();
        run_frame("R9 bad frame", 2, 0, 1, 0, 0, 100, 16'h0800, 86, -1);
        run_frame("R9 next frame clean", 2, -1, -1, 0, 0, 100, 16'h0800, 86, -1);
        run_frame("R9 invalid beat ignored", 3, -1, -1, 0, 0, 100, 16'h0800, 86, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_clean();
        t_crc_class();
        t_malformed();
        t_size();
        t_payload();
        t_restart();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule